// File: doc/BRIEF.md
# Fully Associative Address-Translation Cache

This block caches recent translations from virtual page numbers to physical page numbers for a 4 KB page size. A lookup presents a 32-bit virtual byte address and a read/write flag. One clock later the block reports exactly one outcome:

- **hit**, with the physical byte address;
- **miss**, when no slot holds that page;
- **page fault**, when the matching slot marks the page as not resident;
- **protection fault**, when a write reaches a page that does not permit writes.

The low 12 address bits are the page offset and pass through unchanged.

Software handles a miss. It walks the page table, installs the translation through the fill port, and retries the access. The block chooses the slot to overwrite. It takes the lowest-numbered empty slot if one exists. Otherwise it takes the slot named by a round-robin pointer that advances every clock. When a filled slot is overwritten, the evicted page number and its reference and dirty flags appear on a write-back port, so software can store them in the page table.

Each slot keeps six things:

- an occupied flag, cleared by synchronous reset;
- a 20-bit tag;
- a 20-bit physical page number;
- a resident flag;
- a write-permission flag;
- reference and dirty flags.

Top module: `xlate_cache`

## Requirements
- R1: After synchronous reset every slot is empty: any lookup reports miss, and all result and write-back outputs are 0.
- R2: A lookup that hits reports rsp_hit=1 in the cycle after the request, with rsp_paddr = {stored physical page, vaddr[11:0]}.
- R3: A lookup whose vaddr[31:12] matches no occupied slot reports rsp_miss=1 and rsp_paddr=0.
- R4: A lookup matching a slot installed with fill_res=0 reports rsp_pfault=1, for reads and writes alike.
- R5: A write lookup (lk_write=1) matching a resident slot installed with fill_wok=0 reports rsp_wprot=1 and not a hit. A read of that page hits.
- R6: At most one of rsp_hit, rsp_miss, rsp_pfault and rsp_wprot is 1. All four are 0 in the cycle after a cycle with lk_req=0.
- R7: A hit sets the slot's reference flag, and a write hit also sets its dirty flag. Page faults and protection faults set neither flag.
- R8: While any slot is empty, a fill uses an empty slot, evicts nothing, and wb_valid stays 0.
- R9: A fill into a full cache evicts one occupied slot. In the next cycle wb_valid=1, with wb_vpn, wb_ref and wb_dirty giving that slot's page and flags. The evicted page then misses.
- R10: After a fill, a retried lookup of the installed page hits with the new translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_req | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is a write |
| lk_vaddr | input | 32 | Virtual byte address |
| fill_en | input | 1 | Install a translation |
| fill_vpn | input | 20 | Virtual page to install |
| fill_ppn | input | 20 | Physical page to install |
| fill_res | input | 1 | Page is resident in memory |
| fill_wok | input | 1 | Page permits writes |
| rsp_hit | output | 1 | Lookup hit |
| rsp_miss | output | 1 | No slot matched |
| rsp_pfault | output | 1 | Matched slot not resident |
| rsp_wprot | output | 1 | Write to write-protected page |
| rsp_paddr | output | 32 | Physical byte address on hit, else 0 |
| wb_valid | output | 1 | An occupied slot was evicted by the last fill |
| wb_vpn | output | 20 | Evicted virtual page |
| wb_ref | output | 1 | Evicted slot's reference flag |
| wb_dirty | output | 1 | Evicted slot's dirty flag |

## Verification
The bench fills all sixteen slots and then keeps refilling. Because the round-robin pointer is free-running, the bench does not predict the victim. It identifies the victim from wb_vpn and compares the reported flags against its own record of each page's history. A design that set the reference flag on a fault, or the dirty flag on a refused write, would report wrong flags on eviction. So would a design that evicted a slot while an empty one existed, or that updated the wrong slot. Other tests target the distinct outcomes: a non-resident page, a write to a read-only page (which must not be a hit), and an unknown page. A design that prioritised these wrongly would raise the wrong flag or more than one flag.

// File: rtl/xlate_cache.sv
module xlate_cache #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int OFS_W   = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   lk_req,
  input  logic                   lk_write,
  input  logic [VPN_W+OFS_W-1:0] lk_vaddr,
  input  logic                   fill_en,
  input  logic [VPN_W-1:0]       fill_vpn,
  input  logic [PPN_W-1:0]       fill_ppn,
  input  logic                   fill_res,
  input  logic                   fill_wok,
  output logic                   rsp_hit,
  output logic                   rsp_miss,
  output logic                   rsp_pfault,
  output logic                   rsp_wprot,
  output logic [PPN_W+OFS_W-1:0] rsp_paddr,
  output logic                   wb_valid,
  output logic [VPN_W-1:0]       wb_vpn,
  output logic                   wb_ref,
  output logic                   wb_dirty
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [VPN_W-1:0] tag_q [ENTRIES];
  logic [PPN_W-1:0] ppn_q [ENTRIES];
  logic [ENTRIES-1:0] live_q, res_q, wok_q, ref_q, dirty_q;
  logic [IDX_W-1:0] rr_q;

  logic [ENTRIES-1:0] match;
  logic [VPN_W-1:0] vpn;
  assign vpn = lk_vaddr[VPN_W+OFS_W-1:OFS_W];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = live_q[g] && (tag_q[g] == vpn);
  end

  logic [IDX_W-1:0] hit_idx, free_idx, victim;
  logic any_free;
  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    any_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) hit_idx = IDX_W'(i);
      if (!live_q[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
    end
  end
  assign victim = any_free ? free_idx : rr_q;

  logic found, hit_n, pf_n, wp_n, miss_n;
  assign found  = |match;
  assign miss_n = lk_req && !found;
  assign pf_n   = lk_req && found && !res_q[hit_idx];
  assign wp_n   = lk_req && found && res_q[hit_idx] && lk_write && !wok_q[hit_idx];
  assign hit_n  = lk_req && found && res_q[hit_idx] && (!lk_write || wok_q[hit_idx]);

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q     <= '0;
      rr_q       <= '0;
      rsp_hit    <= 1'b0;
      rsp_miss   <= 1'b0;
      rsp_pfault <= 1'b0;
      rsp_wprot  <= 1'b0;
      rsp_paddr  <= '0;
      wb_valid   <= 1'b0;
      wb_vpn     <= '0;
      wb_ref     <= 1'b0;
      wb_dirty   <= 1'b0;
    end else begin
      rr_q       <= rr_q + 1'b1;
      rsp_hit    <= hit_n;
      rsp_miss   <= miss_n;
      rsp_pfault <= pf_n;
      rsp_wprot  <= wp_n;
      rsp_paddr  <= hit_n ? {ppn_q[hit_idx], lk_vaddr[OFS_W-1:0]} : '0;
      if (hit_n) begin
        ref_q[hit_idx] <= 1'b1;
        if (lk_write) dirty_q[hit_idx] <= 1'b1;
      end
      wb_valid <= fill_en && live_q[victim];
      if (fill_en) begin
        wb_vpn          <= tag_q[victim];
        wb_ref          <= ref_q[victim];
        wb_dirty        <= dirty_q[victim];
        tag_q[victim]   <= fill_vpn;
        ppn_q[victim]   <= fill_ppn;
        live_q[victim]  <= 1'b1;
        res_q[victim]   <= fill_res;
        wok_q[victim]   <= fill_wok;
        ref_q[victim]   <= 1'b0;
        dirty_q[victim] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/xlate_cache_chk.sv
module xlate_cache_chk #(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFS_W   = 12
) (
  input logic               clk,
  input logic               rst,
  input logic               lk_req,
  input logic               lk_write,
  input logic [VA_W-1:0]    lk_vaddr,
  input logic               fill_en,
  input logic               rsp_hit,
  input logic               rsp_miss,
  input logic               rsp_pfault,
  input logic               rsp_wprot,
  input logic [PA_W-1:0]    rsp_paddr,
  input logic               wb_valid,
  input logic [ENTRIES-1:0] live_q
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> !(rsp_hit || rsp_miss || rsp_pfault || rsp_wprot || wb_valid) && live_q == '0);

  a_r6_one_outcome: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rsp_hit, rsp_miss, rsp_pfault, rsp_wprot}));

  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !lk_req |=> !(rsp_hit || rsp_miss || rsp_pfault || rsp_wprot));

  a_r2_offset_passes: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> (!rsp_hit || rsp_paddr[OFS_W-1:0] == $past(lk_vaddr[OFS_W-1:0])));

  a_r5_wprot_on_write: assert property (@(posedge clk) disable iff (rst)
    lk_req && !lk_write |=> !rsp_wprot);

  a_r8_no_evict_free: assert property (@(posedge clk) disable iff (rst)
    fill_en && !(&live_q) |=> !wb_valid);

  a_r9_evict_after_fill: assert property (@(posedge clk) disable iff (rst)
    !fill_en |=> !wb_valid);
endmodule

bind xlate_cache xlate_cache_chk #(
  .ENTRIES(ENTRIES), .VA_W(VPN_W+OFS_W), .PA_W(PPN_W+OFS_W), .OFS_W(OFS_W)
) u_chk (
  .clk(clk), .rst(rst), .lk_req(lk_req), .lk_write(lk_write), .lk_vaddr(lk_vaddr),
  .fill_en(fill_en), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_pfault(rsp_pfault),
  .rsp_wprot(rsp_wprot), .rsp_paddr(rsp_paddr), .wb_valid(wb_valid), .live_q(live_q)
);

// File: tb/sim_xlate_cache.sv
`timescale 1ns/1ps
module sim_xlate_cache;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lk_req = 1'b0, lk_write = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic fill_en = 1'b0, fill_res = 1'b0, fill_wok = 1'b0;
  logic [19:0] fill_vpn = '0, fill_ppn = '0;
  logic rsp_hit, rsp_miss, rsp_pfault, rsp_wprot, wb_valid, wb_ref, wb_dirty;
  logic [31:0] rsp_paddr;
  logic [19:0] wb_vpn;

  int checks = 0, fails = 0;
  logic [19:0] m_vpn [16];
  logic [19:0] m_ppn [16];
  logic m_res [16], m_wok [16], m_ref [16], m_dirty [16];

  always #10 clk = ~clk;

  xlate_cache u0 (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // outcome code: 0 hit, 1 miss, 2 page fault, 3 protection fault
  task automatic look(string req, logic [19:0] vpn, logic [11:0] ofs, logic wr,
                      int code, logic [19:0] ppn);
    @(negedge clk);
    lk_req = 1'b1; lk_write = wr; lk_vaddr = {vpn, ofs};
    @(negedge clk);
    lk_req = 1'b0;
    chk(req, {rsp_hit, rsp_miss, rsp_pfault, rsp_wprot},
        4'b1000 >> code);
    chk(req, rsp_paddr, code == 0 ? {ppn, ofs} : 32'h0);
  endtask

  task automatic fill(logic [19:0] vpn, logic [19:0] ppn, logic res, logic wok);
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_res = res; fill_wok = wok;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle outputs", {rsp_hit, rsp_miss, rsp_pfault, rsp_wprot, wb_valid}, 5'b0);
    chk("R6 idle quiet", rsp_paddr, 32'h0);
    look("R1 empty misses", 20'h12345, 12'h0, 1'b0, 1, 20'h0);
  endtask

  task automatic t_fill_all();
    for (int i = 0; i < 16; i++) begin
      m_vpn[i] = 20'h10000 + 20'(i * 'h111);
      m_ppn[i] = 20'h0A000 + 20'(i * 7);
      m_res[i] = (i != 5);
      m_wok[i] = (i % 2 == 0);
      m_ref[i] = 1'b0; m_dirty[i] = 1'b0;
      fill(m_vpn[i], m_ppn[i], m_res[i], m_wok[i]);
      chk("R8 no eviction while free", wb_valid, 1'b0);
    end
  endtask

  task automatic t_outcomes();
    look("R2 read hit", m_vpn[0], 12'hABC, 1'b0, 0, m_ppn[0]); m_ref[0] = 1'b1;
    look("R7 write hit", m_vpn[2], 12'h004, 1'b1, 0, m_ppn[2]);
    m_ref[2] = 1'b1; m_dirty[2] = 1'b1;
    look("R5 write protected", m_vpn[1], 12'h010, 1'b1, 3, 20'h0);
    look("R5 read of protected page", m_vpn[3], 12'hFFF, 1'b0, 0, m_ppn[3]);
    m_ref[3] = 1'b1;
    look("R4 page fault read", m_vpn[5], 12'h000, 1'b0, 2, 20'h0);
    look("R4 page fault write", m_vpn[5], 12'h008, 1'b1, 2, 20'h0);
    look("R3 unknown page", 20'hFFFFF, 12'h123, 1'b0, 1, 20'h0);
    look("R3 unknown write", 20'h00001, 12'h123, 1'b1, 1, 20'h0);
    look("R2 hit last slot", m_vpn[15], 12'h777, 1'b0, 0, m_ppn[15]);
    m_ref[15] = 1'b1;
  endtask

  task automatic t_evict(int n);
    logic [19:0] nv, np;
    int k;
    nv = 20'h70000 + 20'(n);
    np = 20'h0C000 + 20'(n * 3);
    repeat (n % 5) @(negedge clk);
    fill(nv, np, 1'b1, 1'b1);
    chk("R9 eviction reported", wb_valid, 1'b1);
    k = -1;
    for (int i = 0; i < 16; i++) if (m_vpn[i] == wb_vpn) k = i;
    chk("R9 evicted page was cached", k >= 0, 1'b1);
    if (k >= 0) begin
      chk("R7 R9 evicted ref flag", wb_ref, m_ref[k]);
      chk("R7 R9 evicted dirty flag", wb_dirty, m_dirty[k]);
      look("R9 evicted page misses", m_vpn[k], 12'h0, 1'b0, 1, 20'h0);
      m_vpn[k] = nv; m_ppn[k] = np; m_res[k] = 1'b1; m_wok[k] = 1'b1;
      m_ref[k] = 1'b1; m_dirty[k] = (n % 2 == 0);
      look("R10 retry hits", nv, 12'h5A5, n % 2 == 0, 0, np);
    end
  endtask

  initial begin
    t_reset();
    t_fill_all();
    t_outcomes();
    for (int n = 0; n < 24; n++) t_evict(n);
    t_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule